// File: doc/BRIEF.md
# Wake Event Generator for a Network Controller

This block drives the active-low power-management event line of a network controller. Three sources can raise an event: a link that comes up or goes down, a strobe from the packet filter reporting a wake frame, and a strobe reporting a magic frame. The event line is open-drain. The block only signals when to pull it low, and a pull-up on the board releases it.

Right after reset the block samples a configuration bit from nonvolatile storage. If the bit is set, the block starts in a preboot wake mode. In that mode only magic frames and link changes count. A magic frame stretches the event into a fixed pulse, 52 ms long by default, and the activity LED shows only frames that passed the station-address or broadcast filter. The mode ends for good once the host writes a memory or I/O base address.

Outside that mode, with the configuration bit clear, an event reaches the line only if two enables agree: the power-management enable and the configure-command enable. The reset input is asserted asynchronously, and its release must be synchronous to `clk`.

Top module: `pme_event_gen`

## Requirements
- R1: While `rst_n` is low, `pme_pull_low_o`, `led_o` and `wol_mode_o` are all 0.
- R2: On the first clock edge after reset, `wol_mode_o` takes the value of `wol_cfg_i` and the configuration bit is latched. Later changes of `wol_cfg_i` have no effect until the next reset.
- R3: `bar_wr_i` sampled high clears `wol_mode_o` at that edge, including on the first edge. The mode stays clear until the next reset.
- R4: The link is taken as down at reset. Each change of `link_up_i`, in either direction, raises `pme_pull_low_o` for one cycle. The rise comes after the third rising edge that follows the change: two synchronizer stages and one compare stage.
- R5: Outside wake mode, `wake_pkt_i` or `magic_pkt_i` sampled high raises `pme_pull_low_o` for one cycle after that edge.
- R6: When the latched configuration bit is 0, an event reaches the line only if `pm_en_i` and `cmd_en_i` are both 1 at the edge that samples the event. When the bit is 1, neither enable has any effect.
- R7: In wake mode, `magic_pkt_i` starts a pulse on `pme_pull_low_o`. The pulse begins after that edge and lasts exactly CLK_KHZ*PULSE_MS cycles.
- R8: A magic strobe while a pulse is running neither restarts nor extends it. A pulse that has started runs to its end even if the mode ends during it.
- R9: In wake mode, `wake_pkt_i` does not raise `pme_pull_low_o`.
- R10: `led_o` is registered. In wake mode it follows `addr_pass_i`; otherwise it follows `act_frame_i`. The mode used is the one in force before the sampling edge.
- R11: Link changes raise the event in wake mode as well as in the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| link_up_i | input | 1 | Link valid level, asynchronous to clk |
| wake_pkt_i | input | 1 | Wake frame matched strobe |
| magic_pkt_i | input | 1 | Magic frame matched strobe |
| wol_cfg_i | input | 1 | Preboot wake configuration bit |
| pm_en_i | input | 1 | Power-management event enable |
| cmd_en_i | input | 1 | Configure-command event enable |
| bar_wr_i | input | 1 | Base address programmed strobe |
| act_frame_i | input | 1 | Any receive activity |
| addr_pass_i | input | 1 | Frame passed station-address or broadcast filter |
| pme_pull_low_o | output | 1 | 1 = pull the event line low |
| led_o | output | 1 | Activity LED drive |
| wol_mode_o | output | 1 | 1 = preboot wake mode |

## Verification
The bench first checks each wake strobe alone with both enables set. It then steps through all four enable combinations, which separates an AND gate from an OR gate or a missing gate. It moves the link up and later down, so that both directions and the three-stage delay are confirmed. After a reset with the configuration bit set, it sends magic frames: a single one measures the pulse length, overlapping ones show the pulse is not retriggered, and one followed by a base-address write shows the pulse survives the mode exit. Wake strobes, LED inputs and link moves within that mode tell the wake-mode behaviour apart from the active-mode behaviour.

// File: rtl/pme_event_pkg.sv
package pme_event_pkg;
  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_WOL    = 1'b1
  } pm_mode_e;
endpackage

// File: rtl/pme_link_mon.sv
module pme_link_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_i,
  output logic chg_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   link_q, link_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], link_i};
    link_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      link_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      link_q <= link_d;
    end
  end

  // either direction of change
  assign chg_o = sync_q[SYNC_STAGES-1] ^ link_q;
endmodule

// File: rtl/pme_mode_ctl.sv
module pme_mode_ctl
  import pme_event_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wol_cfg_i,
  input  logic     bar_wr_i,
  input  logic     act_frame_i,
  input  logic     addr_pass_i,
  output pm_mode_e mode_o,
  output logic     cfg_wol_o,
  output logic     led_o
);
  logic     init_q, init_d;
  logic     cfg_q, cfg_d;
  pm_mode_e mode_q, mode_d;
  logic     led_q, led_d;

  always_comb begin
    init_d = 1'b0;
    cfg_d  = init_q ? wol_cfg_i : cfg_q;
    if (bar_wr_i) begin
      mode_d = MODE_ACTIVE;
    end else if (init_q) begin
      mode_d = wol_cfg_i ? MODE_WOL : MODE_ACTIVE;
    end else begin
      mode_d = mode_q;
    end
    led_d = (mode_q == MODE_WOL) ? addr_pass_i : act_frame_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      cfg_q  <= 1'b0;
      mode_q <= MODE_ACTIVE;
      led_q  <= 1'b0;
    end else begin
      init_q <= init_d;
      cfg_q  <= cfg_d;
      mode_q <= mode_d;
      led_q  <= led_d;
    end
  end

  assign mode_o    = mode_q;
  assign cfg_wol_o = cfg_q;
  assign led_o     = led_q;
endmodule

// File: rtl/pme_pulse_stretch.sv
module pme_pulse_stretch #(
  parameter int unsigned PULSE_CYC = 52,
  parameter int          CNT_W     = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = (cnt_q != '0) || start_i;

  always_comb begin
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = CNT_W'(PULSE_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/pme_event_gen.sv
module pme_event_gen
  import pme_event_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 200000,
  parameter int unsigned PULSE_MS    = 52,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up_i,
  input  logic wake_pkt_i,
  input  logic magic_pkt_i,
  input  logic wol_cfg_i,
  input  logic pm_en_i,
  input  logic cmd_en_i,
  input  logic bar_wr_i,
  input  logic act_frame_i,
  input  logic addr_pass_i,
  output logic pme_pull_low_o,
  output logic led_o,
  output logic wol_mode_o
);
  localparam int unsigned PULSE_CYC = CLK_KHZ * PULSE_MS;

  logic     link_chg;
  pm_mode_e mode;
  logic     cfg_wol;
  logic     in_wol;
  logic     event_ok;
  logic     norm_d, norm_q;
  logic     pulse_on;

  pme_link_mon #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk    (clk),
    .rst_n  (rst_n),
    .link_i (link_up_i),
    .chg_o  (link_chg)
  );

  pme_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wol_cfg_i   (wol_cfg_i),
    .bar_wr_i    (bar_wr_i),
    .act_frame_i (act_frame_i),
    .addr_pass_i (addr_pass_i),
    .mode_o      (mode),
    .cfg_wol_o   (cfg_wol),
    .led_o       (led_o)
  );

  assign in_wol = (mode == MODE_WOL);

  pme_pulse_stretch #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (in_wol && magic_pkt_i),
    .active_o (pulse_on)
  );

  always_comb begin
    event_ok = cfg_wol || (pm_en_i && cmd_en_i);
    norm_d   = event_ok && (link_chg || (!in_wol && (wake_pkt_i || magic_pkt_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= 1'b0;
    end else begin
      norm_q <= norm_d;
    end
  end

  assign pme_pull_low_o = norm_q || pulse_on;
  assign wol_mode_o     = in_wol;
endmodule

// File: rtl/pme_event_gen_chk.sv
module pme_event_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic magic_pkt_i,
  input logic pm_en_i,
  input logic cmd_en_i,
  input logic bar_wr_i,
  input logic addr_pass_i,
  input logic cfg_wol,
  input logic pme_pull_low_o,
  input logic led_o,
  input logic wol_mode_o
);
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= 1'b0;
  end

  assert_mode_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wol_mode_o) |-> $past(first_q));

  assert_bar_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bar_wr_i |=> !wol_mode_o);

  assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wol && !(pm_en_i && cmd_en_i)) |=> !pme_pull_low_o);

  assert_magic_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wol_mode_o && magic_pkt_i) |=> pme_pull_low_o);

  assert_led_mux_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wol_mode_o |=> (led_o == $past(addr_pass_i)));
endmodule

bind pme_event_gen pme_event_gen_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .magic_pkt_i    (magic_pkt_i),
  .pm_en_i        (pm_en_i),
  .cmd_en_i       (cmd_en_i),
  .bar_wr_i       (bar_wr_i),
  .addr_pass_i    (addr_pass_i),
  .cfg_wol        (cfg_wol),
  .pme_pull_low_o (pme_pull_low_o),
  .led_o          (led_o),
  .wol_mode_o     (wol_mode_o)
);

// File: tb/pme_event_gen_tb.sv
`timescale 1ns/1ps
module pme_event_gen_tb;
  localparam int PULSE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up_i = 0, wake_pkt_i = 0, magic_pkt_i = 0, wol_cfg_i = 0;
  logic pm_en_i = 0, cmd_en_i = 0, bar_wr_i = 0, act_frame_i = 0, addr_pass_i = 0;
  logic pme_pull_low_o, led_o, wol_mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  pme_event_gen #(.CLK_KHZ(1), .PULSE_MS(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .wake_pkt_i(wake_pkt_i),
    .magic_pkt_i(magic_pkt_i), .wol_cfg_i(wol_cfg_i), .pm_en_i(pm_en_i),
    .cmd_en_i(cmd_en_i), .bar_wr_i(bar_wr_i), .act_frame_i(act_frame_i),
    .addr_pass_i(addr_pass_i), .pme_pull_low_o(pme_pull_low_o), .led_o(led_o),
    .wol_mode_o(wol_mode_o)
  );

  // behavioural reference
  bit m_init, m_cfg, m_mode, m_led, m_norm, m_chg, m_old;
  bit lnk[$];
  int m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 1; m_cfg = 0; m_mode = 0; m_led = 0; m_norm = 0; m_left = 0;
      lnk = '{0, 0, 0};
    end else begin
      m_chg = (lnk[1] != lnk[0]);
      m_old = m_mode;
      m_norm = (m_cfg || (pm_en_i && cmd_en_i)) &&
               (m_chg || (!m_old && (wake_pkt_i || magic_pkt_i)));
      if (m_left > 0) m_left--;
      else if (m_old && magic_pkt_i) m_left = PULSE;
      m_led = m_old ? addr_pass_i : act_frame_i;
      if (m_init) begin
        m_cfg = wol_cfg_i; m_mode = wol_cfg_i && !bar_wr_i; m_init = 0;
      end else begin
        m_mode = m_mode && !bar_wr_i;
      end
      void'(lnk.pop_front());
      lnk.push_back(link_up_i);
    end
  end

  task automatic chk(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("pme", pme_pull_low_o, m_norm || (m_left != 0));
      chk("led", led_o, m_led);
      chk("mode", wol_mode_o, m_mode);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  task automatic do_reset(bit cfg);
    @(negedge clk);
    rst_n = 0; wol_cfg_i = cfg;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  int pulse_len;

  initial begin
    // R1 reset values checked on every cycle while rst_n is low
    do_reset(0);
    phase = "R2"; wol_cfg_i = 1; cyc(4);            // late cfg change ignored
    pm_en_i = 1; cmd_en_i = 1;
    phase = "R5"; strobe(wake_pkt_i); cyc(3); strobe(magic_pkt_i); cyc(3);
    phase = "R6";
    for (int k = 0; k < 4; k++) begin
      pm_en_i = k[0]; cmd_en_i = k[1];
      strobe(wake_pkt_i); cyc(2);
    end
    pm_en_i = 1; cmd_en_i = 1;
    phase = "R4"; link_up_i = 1; cyc(6); link_up_i = 0; cyc(6);
    pm_en_i = 0; link_up_i = 1; cyc(6); pm_en_i = 1;
    phase = "R10"; act_frame_i = 1; cyc(2); addr_pass_i = 1; act_frame_i = 0; cyc(2);

    do_reset(1);
    wol_cfg_i = 0; pm_en_i = 0; cmd_en_i = 0;
    phase = "R2"; cyc(3);
    phase = "R7"; pulse_len = 0;
    strobe(magic_pkt_i);
    while (pme_pull_low_o) begin pulse_len++; cyc(1); end
    checks++;
    if (pulse_len != PULSE) begin
      errors++;
      $display("FAIL R7 pulse length act=%0d exp=%0d", pulse_len, PULSE);
    end
    phase = "R8"; strobe(magic_pkt_i); cyc(5); strobe(magic_pkt_i); cyc(PULSE);
    phase = "R9"; strobe(wake_pkt_i); cyc(3);
    phase = "R10"; addr_pass_i = 1; act_frame_i = 0; cyc(2);
    addr_pass_i = 0; act_frame_i = 1; cyc(2); act_frame_i = 0;
    phase = "R11"; link_up_i = 0; cyc(6);
    phase = "R8"; strobe(magic_pkt_i); cyc(3);
    phase = "R3"; strobe(bar_wr_i); cyc(PULSE);
    strobe(magic_pkt_i); cyc(3); addr_pass_i = 1; cyc(2);

    do_reset(1);
    phase = "R3"; bar_wr_i = 1; cyc(1); bar_wr_i = 0; cyc(3);
    strobe(magic_pkt_i); cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule